// File: doc/BRIEF.md
# Fully Associative Address Translation Cache

This block keeps a small set of recent virtual-to-physical page mappings so that a processor request can be translated without a page-table walk. A lookup presents a 32-bit virtual address. The upper 20 bits are the virtual page number, and every valid entry compares against that number at the same moment. On a match the block returns the cached physical frame, joined to the untranslated 12-bit page offset, together with the permission bits stored with that frame. If no entry matches, the block reports a miss, and the page-table walker must service the request.

After a miss the walker writes the mapping back through the fill port. An empty slot is used first. Once every slot is occupied, a rotating pointer picks the slot to replace. A single-cycle flush empties the whole buffer. Flush is pulsed when the page-directory base register is written, so that no stale translations survive a change of address space. Because each entry stores its permission bits, a hit can still be turned into a page fault when the access breaks write or privilege protection.

Top module: `tlb_cam`

## Requirements
- R1: After reset no entry is valid, so any lookup with `req`=1 gives `miss`=1 and `hit`=0.
- R2: With `req`=1, a lookup whose address bits [31:12] equal the page number of a valid entry gives `hit`=1 and `miss`=0 in the same cycle. `pa`[31:12] is then that entry's frame and `pa`[11:0] equals `va`[11:0]. With `req`=0, `hit` and `miss` are both 0.
- R3: A lookup whose page number matches no valid entry gives `miss`=1, `hit`=0 and `fault`=0.
- R4: A `fill_en` pulse without `flush` writes its mapping on the rising clock edge. A lookup of that page from the next cycle on hits with the filled frame and permission bits (`hit_present`, `hit_writable`, `hit_user`).
- R5: On a hit, `fault`=1 exactly when one of these holds: the entry is not present; `wr`=1 and the entry is not writable; `user`=1 and the entry is not a user page. Otherwise `fault`=0.
- R6: A fill whose page number matches a valid entry overwrites that entry, and no second copy is made. Later lookups return the new frame.
- R7: Fills go to empty slots first, lowest index first. When all ENTRIES slots are valid, a fill of a new page replaces slots in rotating order starting from slot 0. With the default of 16 entries, the 17th distinct page evicts the 1st, and the 18th evicts the 2nd.
- R8: A `flush` pulse clears every entry on that clock edge. From the next cycle on, all lookups miss, and the replacement order restarts at slot 0.
- R9: When `flush` and `fill_en` are asserted in the same cycle, the flush wins and the fill is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Lookup request valid |
| va | input | 32 | Virtual address to translate |
| wr | input | 1 | Lookup is a write access |
| user | input | 1 | Lookup is from user mode |
| hit | output | 1 | A valid entry matches the lookup |
| miss | output | 1 | Request with no matching entry; walker needed |
| fault | output | 1 | Hit rejected for protection |
| pa | output | 32 | Translated physical address |
| hit_present | output | 1 | Present bit of the matching entry |
| hit_writable | output | 1 | Writable bit of the matching entry |
| hit_user | output | 1 | User bit of the matching entry |
| fill_en | input | 1 | Write a mapping from the walker |
| fill_vpn | input | 20 | Virtual page number to fill |
| fill_pfn | input | 20 | Physical frame number to fill |
| fill_present | input | 1 | Present bit to store |
| fill_writable | input | 1 | Writable bit to store |
| fill_user | input | 1 | User bit to store |
| flush | input | 1 | Invalidate all entries |

## Verification
The bench checks each protection case on its own: a supervisor read-only page must fault for a write and for a user read, but not for a supervisor read, and a non-present entry must fault for any access. A design that ignored permissions would let these accesses through silently. A refill of a page that is already cached must return the new frame; a design that allocated a second slot would later evict the wrong page, and the hit logic would see two matches. The bench fills every slot and then adds two more pages, checking exactly which old pages are lost, so a pointer that starts at the wrong slot or advances on the wrong event shows up as the wrong eviction. A flush issued in the same cycle as a fill must leave the filled page missing; a design that let the fill win would keep a stale translation.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    localparam int VA_W      = 32;
    localparam int PAGE_BITS = 12;
    localparam int VPN_W     = VA_W - PAGE_BITS;
    localparam int PFN_W     = 20;
    localparam int PA_W      = PFN_W + PAGE_BITS;

    typedef logic [VPN_W-1:0] vpn_t;
    typedef logic [PFN_W-1:0] pfn_t;

    typedef struct packed {
        logic present;
        logic writable;
        logic user;
    } perm_t;

    typedef struct packed {
        vpn_t  vpn;
        pfn_t  pfn;
        perm_t perm;
    } entry_t;

    typedef struct packed {
        logic wr;
        logic user;
    } access_t;

    function automatic logic perm_violation(perm_t p, access_t a);
        return !p.present || (a.wr && !p.writable) || (a.user && !p.user);
    endfunction
endpackage

// File: rtl/tlb_store.sv
module tlb_store
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 16,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               flush,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  entry_t             wr_data,
    input  vpn_t               look_vpn,
    output logic [ENTRIES-1:0] look_match,
    output logic [ENTRIES-1:0] fill_match,
    output logic [ENTRIES-1:0] valid_vec,
    output entry_t             look_data
);
    entry_t             slot [ENTRIES];
    logic [ENTRIES-1:0] valid_q;

    assign valid_vec = valid_q;

    for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst || flush) begin
                valid_q[i] <= 1'b0;
            end else if (wr_en && wr_idx == IDX_W'(i)) begin
                valid_q[i] <= 1'b1;
                slot[i]    <= wr_data;
            end
        end
        assign look_match[i] = valid_q[i] && (slot[i].vpn == look_vpn);
        assign fill_match[i] = valid_q[i] && (slot[i].vpn == wr_data.vpn);
    end

    always_comb begin
        look_data = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (look_match[i]) look_data = look_data | slot[i];
        end
    end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
    parameter int ENTRIES = 16,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               flush,
    input  logic               fill_en,
    input  logic [ENTRIES-1:0] valid_vec,
    input  logic [ENTRIES-1:0] fill_match,
    output logic [IDX_W-1:0]   victim
);
    logic [IDX_W-1:0] rr_ptr;
    logic [IDX_W-1:0] match_idx;
    logic [IDX_W-1:0] free_idx;
    logic             any_match;
    logic             any_free;

    always_comb begin
        match_idx = '0;
        free_idx  = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (fill_match[i]) match_idx = IDX_W'(i);
            if (!valid_vec[i]) free_idx  = IDX_W'(i);
        end
        any_match = |fill_match;
        any_free  = ~&valid_vec;
    end

    always_comb begin
        if (any_match)     victim = match_idx;
        else if (any_free) victim = free_idx;
        else               victim = rr_ptr;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            rr_ptr <= '0;
        end else if (fill_en && !any_match && !any_free) begin
            rr_ptr <= (rr_ptr == IDX_W'(ENTRIES - 1)) ? '0 : rr_ptr + 1'b1;
        end
    end
endmodule

// File: rtl/tlb_cam.sv
module tlb_cam
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req,
    input  logic [31:0] va,
    input  logic        wr,
    input  logic        user,
    output logic        hit,
    output logic        miss,
    output logic        fault,
    output logic [31:0] pa,
    output logic        hit_present,
    output logic        hit_writable,
    output logic        hit_user,
    input  logic        fill_en,
    input  logic [19:0] fill_vpn,
    input  logic [19:0] fill_pfn,
    input  logic        fill_present,
    input  logic        fill_writable,
    input  logic        fill_user,
    input  logic        flush
);
    localparam int IDX_W = $clog2(ENTRIES);

    logic [ENTRIES-1:0] hit_vec;
    logic [ENTRIES-1:0] fill_match;
    logic [ENTRIES-1:0] valid_vec;
    logic [IDX_W-1:0]   victim;
    entry_t             fill_data;
    entry_t             look_data;
    access_t            acc;
    logic               do_fill;
    logic               any_hit;

    assign fill_data.vpn           = fill_vpn;
    assign fill_data.pfn           = fill_pfn;
    assign fill_data.perm.present  = fill_present;
    assign fill_data.perm.writable = fill_writable;
    assign fill_data.perm.user     = fill_user;
    assign do_fill                 = fill_en && !flush;

    tlb_store #(.ENTRIES(ENTRIES)) u_store (
        .clk        (clk),
        .rst        (rst),
        .flush      (flush),
        .wr_en      (do_fill),
        .wr_idx     (victim),
        .wr_data    (fill_data),
        .look_vpn   (va[VA_W-1:PAGE_BITS]),
        .look_match (hit_vec),
        .fill_match (fill_match),
        .valid_vec  (valid_vec),
        .look_data  (look_data)
    );

    tlb_victim #(.ENTRIES(ENTRIES)) u_victim (
        .clk        (clk),
        .rst        (rst),
        .flush      (flush),
        .fill_en    (do_fill),
        .valid_vec  (valid_vec),
        .fill_match (fill_match),
        .victim     (victim)
    );

    assign acc.wr   = wr;
    assign acc.user = user;
    assign any_hit  = |hit_vec;

    always_comb begin
        hit          = req && any_hit;
        miss         = req && !any_hit;
        fault        = hit && perm_violation(look_data.perm, acc);
        pa           = {look_data.pfn, va[PAGE_BITS-1:0]};
        hit_present  = hit && look_data.perm.present;
        hit_writable = hit && look_data.perm.writable;
        hit_user     = hit && look_data.perm.user;
    end
endmodule

// File: rtl/tlb_cam_chk.sv
module tlb_cam_chk #(
    parameter int ENTRIES = 16
) (
    input logic               clk,
    input logic               rst,
    input logic               req,
    input logic               hit,
    input logic               miss,
    input logic               fault,
    input logic               flush,
    input logic [11:0]        va_off,
    input logic [11:0]        pa_off,
    input logic [ENTRIES-1:0] hit_vec
);
    a_r2_hit_miss_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(hit && miss));
    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !req |-> (!hit && !miss));
    a_r2_offset_pass: assert property (@(posedge clk) disable iff (rst)
        hit |-> (pa_off == va_off));
    a_r3_miss_no_fault: assert property (@(posedge clk) disable iff (rst)
        fault |-> hit);
    a_r6_single_match: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit_vec));
    a_r8_flush_clears: assert property (@(posedge clk) disable iff (rst)
        flush |=> (hit_vec == '0));
endmodule

bind tlb_cam tlb_cam_chk #(.ENTRIES(ENTRIES)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .req     (req),
    .hit     (hit),
    .miss    (miss),
    .fault   (fault),
    .flush   (flush),
    .va_off  (va[11:0]),
    .pa_off  (pa[11:0]),
    .hit_vec (hit_vec)
);

// File: tb/sim_tlb_cam.sv
`timescale 1ns/1ps
module sim_tlb_cam;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0;
    logic [31:0] va = '0;
    logic        wr = 1'b0;
    logic        user = 1'b0;
    logic        hit, miss, fault, hit_present, hit_writable, hit_user;
    logic [31:0] pa;
    logic        fill_en = 1'b0;
    logic [19:0] fill_vpn = '0;
    logic [19:0] fill_pfn = '0;
    logic        fill_present = 1'b0;
    logic        fill_writable = 1'b0;
    logic        fill_user = 1'b0;
    logic        flush = 1'b0;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    tlb_cam u0 (
        .clk(clk), .rst(rst), .req(req), .va(va), .wr(wr), .user(user),
        .hit(hit), .miss(miss), .fault(fault), .pa(pa),
        .hit_present(hit_present), .hit_writable(hit_writable), .hit_user(hit_user),
        .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn),
        .fill_present(fill_present), .fill_writable(fill_writable),
        .fill_user(fill_user), .flush(flush)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic look(input logic [31:0] a, input logic w, input logic u);
        @(negedge clk);
        req = 1'b1; va = a; wr = w; user = u;
        #2;
    endtask

    task automatic fill(input logic [19:0] vpn, input logic [19:0] pfn,
                        input logic [2:0] pwu, input logic with_flush);
        @(negedge clk);
        fill_en = 1'b1; fill_vpn = vpn; fill_pfn = pfn;
        {fill_present, fill_writable, fill_user} = pwu;
        flush = with_flush;
        @(negedge clk);
        fill_en = 1'b0; flush = 1'b0;
    endtask

    task automatic do_flush();
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
    endtask

    task automatic t_reset();
        look(32'h0000_1000, 1'b0, 1'b0);
        chk("R1 miss after reset", {31'd0, miss}, 32'd1);
        chk("R1 no hit after reset", {31'd0, hit}, 32'd0);
        @(negedge clk); req = 1'b0; #2;
        chk("R2 idle no hit/miss", {30'd0, hit, miss}, 32'd0);
    endtask

    task automatic t_fill_hit();
        fill(20'h12345, 20'h00ABC, 3'b111, 1'b0);
        look(32'h1234_5678, 1'b1, 1'b1);
        chk("R2 hit", {31'd0, hit}, 32'd1);
        chk("R2 pa", pa, 32'h00AB_C678);
        chk("R4 perms", {29'd0, hit_present, hit_writable, hit_user}, 32'd7);
        chk("R5 no fault full perm", {31'd0, fault}, 32'd0);
    endtask

    task automatic t_miss();
        look(32'h1234_6000, 1'b0, 1'b0);
        chk("R3 miss neighbour page", {29'd0, miss, hit, fault}, 32'd4);
    endtask

    task automatic t_protect();
        fill(20'h20000, 20'h00011, 3'b100, 1'b0);
        fill(20'h30000, 20'h00022, 3'b011, 1'b0);
        look(32'h2000_0004, 1'b0, 1'b0);
        chk("R5 super read ok", {30'd0, hit, fault}, 32'd2);
        chk("R4 perms ro", {29'd0, hit_present, hit_writable, hit_user}, 32'd4);
        look(32'h2000_0004, 1'b1, 1'b0);
        chk("R5 write ro faults", {30'd0, hit, fault}, 32'd3);
        look(32'h2000_0004, 1'b0, 1'b1);
        chk("R5 user super faults", {30'd0, hit, fault}, 32'd3);
        look(32'h3000_0000, 1'b0, 1'b0);
        chk("R5 not present faults", {30'd0, hit, fault}, 32'd3);
    endtask

    task automatic t_overwrite();
        fill(20'h12345, 20'h00DEF, 3'b110, 1'b0);
        look(32'h1234_5678, 1'b0, 1'b0);
        chk("R6 new frame", pa, 32'h00DE_F678);
        chk("R6 new perms", {29'd0, hit_present, hit_writable, hit_user}, 32'd6);
        look(32'h1234_5000, 1'b0, 1'b1);
        chk("R6 user now faults", {31'd0, fault}, 32'd1);
    endtask

    task automatic t_flush();
        do_flush();
        look(32'h1234_5678, 1'b0, 1'b0);
        chk("R8 flushed miss a", {30'd0, miss, hit}, 32'd2);
        look(32'h2000_0000, 1'b0, 1'b0);
        chk("R8 flushed miss b", {30'd0, miss, hit}, 32'd2);
    endtask

    task automatic t_replace();
        int bad;
        for (int i = 0; i < 16; i++) fill(20'h00100 + 20'(i), 20'(i), 3'b111, 1'b0);
        bad = 0;
        for (int i = 0; i < 16; i++) begin
            look({20'h00100 + 20'(i), 12'h000}, 1'b0, 1'b0);
            if (!hit || pa[31:12] != 20'(i)) bad++;
        end
        chk("R7 all 16 resident", bad, 0);
        fill(20'h00200, 20'h00AAA, 3'b111, 1'b0);
        look(32'h0010_0000, 1'b0, 1'b0);
        chk("R7 first evicted", {31'd0, miss}, 32'd1);
        look(32'h0010_1000, 1'b0, 1'b0);
        chk("R7 second kept", {31'd0, hit}, 32'd1);
        look(32'h0020_0000, 1'b0, 1'b0);
        chk("R7 new resident", pa, 32'h00AA_A000);
        fill(20'h00201, 20'h00BBB, 3'b111, 1'b0);
        look(32'h0010_1000, 1'b0, 1'b0);
        chk("R7 second evicted", {31'd0, miss}, 32'd1);
        look(32'h0010_2000, 1'b0, 1'b0);
        chk("R7 third kept", {31'd0, hit}, 32'd1);
    endtask

    task automatic t_flush_restart();
        do_flush();
        for (int i = 0; i < 17; i++) fill(20'h00300 + 20'(i), 20'(i), 3'b111, 1'b0);
        look(32'h0030_0000, 1'b0, 1'b0);
        chk("R8 order restarts at slot 0", {31'd0, miss}, 32'd1);
        look(32'h0030_1000, 1'b0, 1'b0);
        chk("R8 slot 1 kept", {31'd0, hit}, 32'd1);
    endtask

    task automatic t_flush_fill();
        fill(20'h00400, 20'h00444, 3'b111, 1'b1);
        look(32'h0040_0000, 1'b0, 1'b0);
        chk("R9 flush beats fill", {30'd0, miss, hit}, 32'd2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_fill_hit();
        t_miss();
        t_protect();
        t_overwrite();
        t_flush();
        t_replace();
        t_flush_restart();
        t_flush_fill();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #1_000_000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule